// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is a single-channel DMA engine driven through three memory-mapped registers: a control and status register (CSR) at byte offset 0x0, an address register at 0x4 and a byte-count register at 0x8. Software writes a count and then an address to load a buffer. The first buffer becomes the current one. A second buffer waits in a one-deep queue. When the current buffer reaches a count of zero, the queued buffer can take its place without any software action. This lets a driver keep the channel busy by refilling the queue while a transfer runs.

Data moves on a simple memory request/acknowledge port. The engine raises a request for each word and holds the address until the beat is acknowledged. Words are grouped into bursts whose length comes from a CSR field. A CSR bit sets the transfer direction. Three kinds of event are reported through sticky pending bits and one level interrupt: terminal count, a device event pin and an error pin. A soft reset, written through the CSR, stops the channel at once but keeps a bus beat that is already in flight until it is acknowledged.

Top module: `chain_dma`

## Requirements
- R1: After the reset input, the CSR reads as the device ID in bits 31:28 with every other bit zero. The address and count registers read zero, and `irq` and `mem_req` are low.
- R2: Reads at offsets 0x4 and 0x8 return the live current address and the remaining byte count. The count is 24 bits wide: bits 31:24 of a count write are dropped and read back as zero.
- R3: Loading a buffer takes a count write followed by an address write. If no current buffer is held, the load fills the current buffer and sets CSR bits 26 (current loaded) and 25 (channel on). If a current buffer is held, the load fills the queue and sets bit 27 (next loaded). While bit 27 is set, count and address writes are ignored.
- R4: Bursts only start while CSR bit 9 (enable) and bit 25 are set, the error-pending bit (R10) is clear, and a nonzero count remains. Each acknowledged beat adds 4 to the address and, when CSR bit 13 (count enable) is set, subtracts 4 from the count. CSR bits 19:18 set the burst length: 00 gives 4 words, 01 gives 8, 10 gives 1 and 11 gives 16. A burst is cut short when fewer words remain.
- R5: `mem_we` equals CSR bit 8 (1 means the engine writes to memory).
- R6: The beat that brings the count to zero sets CSR bit 14 (terminal count) and bit 0 (interrupt pending). If CSR bit 23 is set, bit 14 is still set but bit 0 is not.
- R7: One cycle after terminal count, if bits 27 and 24 (chain enable) are both set, the queued buffer becomes current. Bit 27 then clears, bit 26 stays set and transfers continue. Otherwise bits 25 and 26 clear.
- R8: Writing a 1 to CSR bit 0, 1 or 14 clears that bit. Writing a 0 leaves it unchanged.
- R9: `irq` is high exactly when CSR bit 4 (interrupt enable) is set and bit 0 or bit 1 is set.
- R10: A high level on `err_in` sets CSR bit 1 (error pending) and clears bit 25. At most one more beat then completes, and no new burst starts. When CSR bit 22 is set, `err_in` has no effect.
- R11: A high level on `dev_evt` sets CSR bit 0 without bit 14. While an error is pending, neither a device event nor a terminal count sets bit 0.
- R12: Writing 1 to CSR bit 7 clears all control and status bits. If a beat is outstanding, CSR bits 2 (draining) and 10 (cycle pending) stay set and `mem_req` stays high until that beat is acknowledged, then all three drop. CSR bit 16, when set beforehand, stops bit 2 from being raised.
- R13: With CSR bit 9 clear, no request is issued even when a buffer is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat direction, 1 = write to memory |
| mem_addr | output | 32 | Beat address |
| mem_ack | input | 1 | Beat acknowledge |
| dev_evt | input | 1 | Device event |
| err_in | input | 1 | Bus error indication |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a soft reset that lands while a beat is waiting for its acknowledge. The bench creates it by gating its memory responder off, so the first request of a burst stalls. It then writes the reset bit and confirms that the request, the draining bit and the cycle-pending bit all persist. Finally it re-enables acknowledges and confirms that exactly one more beat completes and everything drops. Chaining is reached by queuing a second buffer before enabling the channel, and the bench shows it took effect through the address sequence seen on the memory port.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter logic [3:0] DEV_ID = 4'hA,
  parameter int         CNT_W  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic        dev_evt,
  input  logic        err_in,
  output logic        irq
);

  localparam logic [3:0] OFF_CSR  = 4'h0;
  localparam logic [3:0] OFF_ADDR = 4'h4;
  localparam logic [3:0] OFF_CNT  = 4'h8;
  localparam logic [CNT_W-1:0] WORD_B = CNT_W'(4);

  logic       int_en, wr_dir, dma_en, cnt_en, dis_drn, dis_err, tci_dis, en_next;
  logic [1:0] bsz;
  logic       int_pend, err_pend, tc, draining, dma_on, a_loaded, na_loaded;
  logic       in_burst, done_q;
  logic [31:0]      cur_addr, nxt_addr;
  logic [CNT_W-1:0] cur_cnt, nxt_cnt, stage_cnt;
  logic [4:0]       burst_left, blen, first_beats;
  logic [CNT_W:0]   words_left;
  logic [CNT_W-1:0] dec;
  logic [31:0]      csr_view;

  wire wr_csr   = reg_wr && (reg_addr == OFF_CSR);
  wire wr_adr   = reg_wr && (reg_addr == OFF_ADDR);
  wire wr_cnt   = reg_wr && (reg_addr == OFF_CNT);
  wire soft_rst = wr_csr && reg_wdata[7];
  wire beat     = mem_req && mem_ack;
  wire err_hit  = err_in && !dis_err;
  wire cnt_last = cnt_en && (cur_cnt <= WORD_B);
  wire term     = beat && cnt_last && dma_on;
  wire promote  = done_q && na_loaded && en_next;
  wire cur_free = !a_loaded || (done_q && !promote);
  wire ld_cur   = wr_adr && !na_loaded && cur_free;
  wire ld_nxt   = wr_adr && !na_loaded && !cur_free;
  wire go       = dma_on && dma_en && !err_pend && !done_q && !soft_rst &&
                  (!cnt_en || cur_cnt != '0);
  wire end_beat = beat && (burst_left == 5'd1 || cnt_last || !dma_on ||
                           err_pend || err_hit || soft_rst);

  always_comb begin
    case (bsz)
      2'b00:   blen = 5'd4;
      2'b01:   blen = 5'd8;
      2'b10:   blen = 5'd1;
      default: blen = 5'd16;
    endcase
  end

  assign words_left  = ({1'b0, cur_cnt} + (CNT_W+1)'(3)) >> 2;
  assign first_beats = (!cnt_en || words_left >= (CNT_W+1)'(blen)) ? blen : words_left[4:0];
  assign dec         = (cur_cnt >= WORD_B) ? WORD_B : cur_cnt;

  assign mem_req  = in_burst;
  assign mem_we   = wr_dir;
  assign mem_addr = cur_addr;
  assign irq      = int_en && (int_pend || err_pend);

  // control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      int_en <= 1'b0; wr_dir <= 1'b0; dma_en <= 1'b0; cnt_en <= 1'b0;
      dis_drn <= 1'b0; dis_err <= 1'b0; tci_dis <= 1'b0; en_next <= 1'b0;
      bsz <= 2'b00;
    end else if (wr_csr) begin
      int_en  <= reg_wdata[4];
      wr_dir  <= reg_wdata[8];
      dma_en  <= reg_wdata[9];
      cnt_en  <= reg_wdata[13];
      dis_drn <= reg_wdata[16];
      bsz     <= reg_wdata[19:18];
      dis_err <= reg_wdata[22];
      tci_dis <= reg_wdata[23];
      en_next <= reg_wdata[24];
    end
  end

  // burst sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst   <= 1'b0;
      burst_left <= '0;
    end else if (!in_burst) begin
      if (go) begin
        in_burst   <= 1'b1;
        burst_left <= first_beats;
      end
    end else if (beat) begin
      burst_left <= burst_left - 5'd1;
      if (end_beat) in_burst <= 1'b0;
    end
  end

  // buffer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_cnt   <= '0;
      nxt_addr  <= '0;
      nxt_cnt   <= '0;
      stage_cnt <= '0;
    end else begin
      if (wr_cnt && !na_loaded) stage_cnt <= reg_wdata[CNT_W-1:0];
      if (ld_nxt) begin
        nxt_addr <= reg_wdata;
        nxt_cnt  <= stage_cnt;
      end
      if (ld_cur) begin
        cur_addr <= reg_wdata;
        cur_cnt  <= stage_cnt;
      end else if (promote) begin
        cur_addr <= nxt_addr;
        cur_cnt  <= nxt_cnt;
      end else if (beat) begin
        cur_addr <= cur_addr + 32'd4;
        if (cnt_en) cur_cnt <= cur_cnt - dec;
      end
    end
  end

  // channel state flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      a_loaded  <= 1'b0;
      na_loaded <= 1'b0;
      dma_on    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= term;
      if (ld_cur) a_loaded <= 1'b1;
      else if (done_q && !promote) a_loaded <= 1'b0;
      if (ld_nxt) na_loaded <= 1'b1;
      else if (promote) na_loaded <= 1'b0;
      if (err_hit) dma_on <= 1'b0;
      else if (ld_cur) dma_on <= 1'b1;
      else if (done_q && !promote) dma_on <= 1'b0;
    end
  end

  // event bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      tc       <= 1'b0;
      int_pend <= 1'b0;
      err_pend <= 1'b0;
    end else begin
      if (term) tc <= 1'b1;
      else if (wr_csr && reg_wdata[14]) tc <= 1'b0;
      if (((term && !tci_dis) || dev_evt) && !err_pend && !err_hit) int_pend <= 1'b1;
      else if (wr_csr && reg_wdata[0]) int_pend <= 1'b0;
      if (err_hit) err_pend <= 1'b1;
      else if (wr_csr && reg_wdata[1]) err_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) draining <= 1'b0;
    else if (soft_rst) draining <= in_burst && !beat && !dis_drn;
    else if (beat || !in_burst) draining <= 1'b0;
  end

  always_comb begin
    csr_view        = '0;
    csr_view[0]     = int_pend;
    csr_view[1]     = err_pend;
    csr_view[2]     = draining;
    csr_view[4]     = int_en;
    csr_view[8]     = wr_dir;
    csr_view[9]     = dma_en;
    csr_view[10]    = in_burst;
    csr_view[13]    = cnt_en;
    csr_view[14]    = tc;
    csr_view[16]    = dis_drn;
    csr_view[19:18] = bsz;
    csr_view[22]    = dis_err;
    csr_view[23]    = tci_dis;
    csr_view[24]    = en_next;
    csr_view[25]    = dma_on;
    csr_view[26]    = a_loaded;
    csr_view[27]    = na_loaded;
    csr_view[31:28] = DEV_ID;
  end

  always_comb begin
    case (reg_addr)
      OFF_CSR:  reg_rdata = csr_view;
      OFF_ADDR: reg_rdata = cur_addr;
      OFF_CNT:  reg_rdata = 32'(cur_cnt);
      default:  reg_rdata = '0;
    endcase
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !reg_wr |=> mem_req && $stable(mem_addr));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !reg_wr |=> mem_addr == $past(mem_addr) + 32'd4);

  p_next_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    na_loaded && reg_wr && reg_addr == OFF_ADDR |=> nxt_addr == $past(nxt_addr));

  p_tc_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> cur_cnt == '0);

  p_err_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pend && !mem_req |=> !mem_req);

  p_drain_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> mem_req);

endmodule

// File: tb/chain_dma_tb.sv
module chain_dma_tb;
  localparam logic [3:0] DEV = 4'hA;
  localparam logic [3:0] A_CSR = 4'h0, A_ADR = 4'h4, A_CNT = 4'h8;
  localparam logic [31:0] B_INT = 32'h1, B_ERR = 32'h2, B_DRN = 32'h4, B_IEN = 32'h10,
                          B_RST = 32'h80, B_WR = 32'h100, B_EN = 32'h200, B_CYC = 32'h400,
                          B_CEN = 32'h2000, B_TC = 32'h4000, B_DERR = 32'h400000,
                          B_TCID = 32'h800000, B_NXT = 32'h1000000, B_ON = 32'h2000000,
                          B_AL = 32'h4000000, B_NAL = 32'h8000000;
  localparam logic [31:0] DEVW = {DEV, 28'h0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_addr;
  logic mem_req, mem_we, mem_ack, irq;
  logic dev_evt = 1'b0, err_in = 1'b0, ack_en = 1'b1;
  int checks = 0, errs = 0;
  int beats = 0, bursts = 0, we_bad = 0;
  logic exp_we = 1'b0, prev_req = 1'b0;
  logic [31:0] alog [0:63];

  always #4 clk = ~clk;
  assign mem_ack = ack_en & mem_req;

  chain_dma #(.DEV_ID(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .dev_evt(dev_evt), .err_in(err_in), .irq(irq));

  always @(negedge clk) begin
    if (mem_req && !prev_req) bursts++;
    if (mem_req && mem_ack) begin
      if (beats < 64) alog[beats] = mem_addr;
      if (mem_we !== exp_we) we_bad++;
      beats++;
    end
    prev_req = mem_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input bit is_err);
    step(1);
    if (is_err) err_in = 1'b1; else dev_evt = 1'b1;
    step(1);
    err_in = 1'b0; dev_evt = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(A_CSR, v);
      if (!v[25] && !mem_req) break;
      step(1);
    end
    step(2);
  endtask

  task automatic fresh();
    ack_en = 1'b1;
    wr(A_CSR, B_RST);
    step(2);
    beats = 0; bursts = 0; we_bad = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CSR, v); chk("R1 csr", v, DEVW);
    rd(A_ADR, v); chk("R1 addr", v, 32'h0);
    rd(A_CNT, v); chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 req", {31'h0, mem_req}, 32'h0);
  endtask

  task automatic t_load_chain();
    logic [31:0] v, ctl;
    fresh();
    ctl = B_CEN | B_NXT | (32'h3 << 18);
    exp_we = 1'b0;
    wr(A_CSR, ctl);
    wr(A_CNT, 32'hFF000040); wr(A_ADR, 32'h1000);
    rd(A_CSR, v); chk("R3 first load flags", v, DEVW | ctl | B_ON | B_AL);
    rd(A_ADR, v); chk("R2 address readback", v, 32'h1000);
    rd(A_CNT, v); chk("R2 count 24-bit", v, 32'h40);
    wr(A_CNT, 32'h20); wr(A_ADR, 32'h2000);
    rd(A_CSR, v); chk("R3 queue flag", v & B_NAL, B_NAL);
    wr(A_CNT, 32'h80); wr(A_ADR, 32'h3000);
    rd(A_ADR, v); chk("R3 refused load addr", v, 32'h1000);
    rd(A_CNT, v); chk("R3 refused load count", v, 32'h40);
    wr(A_CSR, ctl | B_EN);
    wait_idle();
    chk("R7 beats", beats, 24);
    chk("R7 bursts", bursts, 2);
    chk("R7 last of first", alog[15], 32'h103C);
    chk("R7 first of next", alog[16], 32'h2000);
    chk("R7 last of next", alog[23], 32'h201C);
    chk("R5 direction read", we_bad, 0);
    rd(A_ADR, v); chk("R7 final addr", v, 32'h2020);
    rd(A_CNT, v); chk("R7 final count", v, 32'h0);
    rd(A_CSR, v); chk("R7 flags after end", v & (B_ON | B_AL | B_NAL | B_TC | B_INT), B_TC | B_INT);
    chk("R9 irq masked", {31'h0, irq}, 32'h0);
    wr(A_CSR, ctl | B_IEN);
    chk("R9 irq enabled", {31'h0, irq}, 32'h1);
    rd(A_CSR, v); chk("R8 zero keeps", v & (B_TC | B_INT), B_TC | B_INT);
    wr(A_CSR, ctl | B_IEN | B_TC | B_INT);
    rd(A_CSR, v); chk("R8 one clears", v & (B_TC | B_INT), 32'h0);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_nochain();
    logic [31:0] v;
    fresh();
    wr(A_CSR, B_CEN);
    wr(A_CNT, 32'h10); wr(A_ADR, 32'h400);
    wr(A_CNT, 32'h8);  wr(A_ADR, 32'h800);
    wr(A_CSR, B_CEN | B_EN);
    wait_idle();
    chk("R7 no chain beats", beats, 4);
    rd(A_CSR, v); chk("R7 no chain flags", v & (B_ON | B_AL | B_NAL), B_NAL);
  endtask

  task automatic t_burst(input logic [1:0] enc, input logic [31:0] cnt,
                         input int exp_bursts, input logic dir);
    logic [31:0] v, ctl;
    fresh();
    exp_we = dir;
    ctl = B_IEN | B_CEN | ({30'h0, enc} << 18) | (dir ? B_WR : 32'h0);
    wr(A_CSR, ctl);
    wr(A_CNT, cnt); wr(A_ADR, 32'h100);
    step(10);
    chk("R13 idle without enable", beats, 0);
    wr(A_CSR, ctl | B_EN);
    wait_idle();
    chk("R4 beat count", beats, int'(cnt >> 2));
    chk("R4 burst count", bursts, exp_bursts);
    chk("R4 first addr", alog[0], 32'h100);
    chk("R4 last addr", alog[(cnt >> 2) - 1], 32'h100 + cnt - 4);
    chk("R5 direction", we_bad, 0);
    rd(A_ADR, v); chk("R4 addr register", v, 32'h100 + cnt);
    rd(A_CNT, v); chk("R4 count register", v, 32'h0);
    rd(A_CSR, v); chk("R6 terminal flags", v & (B_TC | B_INT), B_TC | B_INT);
    chk("R6 irq", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_tci();
    logic [31:0] v;
    fresh();
    wr(A_CSR, B_IEN | B_CEN | B_TCID | B_EN | (32'h2 << 18));
    wr(A_CNT, 32'h4); wr(A_ADR, 32'h40);
    wait_idle();
    rd(A_CSR, v); chk("R6 tc without interrupt", v & (B_TC | B_INT), B_TC);
    chk("R6 irq suppressed", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    int b0;
    fresh();
    wr(A_CSR, B_IEN | B_CEN | B_EN);
    wr(A_CNT, 32'h100); wr(A_ADR, 32'h0);
    step(6);
    pulse(1'b1);
    step(3);
    b0 = beats;
    step(20);
    chk("R10 beats stop", beats, b0);
    chk("R10 halted early", {31'h0, b0 < 64}, 32'h1);
    rd(A_CSR, v); chk("R10 error flags", v & (B_ERR | B_ON | B_INT), B_ERR);
    chk("R10 irq", {31'h0, irq}, 32'h1);
    pulse(1'b0);
    rd(A_CSR, v); chk("R11 error priority", v & B_INT, 32'h0);
    wr(A_CSR, B_IEN | B_CEN | B_EN | B_ERR);
    rd(A_CSR, v); chk("R8 error cleared", v & B_ERR, 32'h0);
    chk("R9 irq after clear", {31'h0, irq}, 32'h0);
    fresh();
    wr(A_CSR, B_CEN | B_EN | B_DERR);
    wr(A_CNT, 32'h10); wr(A_ADR, 32'h0);
    pulse(1'b1);
    wait_idle();
    chk("R10 masked error beats", beats, 4);
    rd(A_CSR, v); chk("R10 masked error flag", v & B_ERR, 32'h0);
  endtask

  task automatic t_dev();
    logic [31:0] v;
    fresh();
    wr(A_CSR, B_IEN);
    pulse(1'b0);
    rd(A_CSR, v); chk("R11 device event", v & (B_INT | B_TC), B_INT);
    chk("R11 irq", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_drain();
    logic [31:0] v;
    fresh();
    ack_en = 1'b0;
    wr(A_CSR, B_CEN | B_EN | (32'h3 << 18));
    wr(A_CNT, 32'h40); wr(A_ADR, 32'h500);
    step(3);
    chk("R12 stalled request", {31'h0, mem_req}, 32'h1);
    wr(A_CSR, B_RST);
    rd(A_CSR, v); chk("R12 draining view", v, DEVW | B_DRN | B_CYC);
    step(3);
    chk("R12 request held", {31'h0, mem_req}, 32'h1);
    ack_en = 1'b1;
    step(2);
    chk("R12 request dropped", {31'h0, mem_req}, 32'h0);
    chk("R12 one beat", beats, 1);
    rd(A_CSR, v); chk("R12 drained view", v, DEVW);
    step(10);
    chk("R12 no further beats", beats, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_load_chain();
    t_nochain();
    t_burst(2'b00, 32'h18, 2, 1'b1);
    t_burst(2'b01, 32'h28, 2, 1'b0);
    t_burst(2'b10, 32'h0C, 3, 1'b1);
    t_burst(2'b11, 32'h28, 1, 1'b0);
    t_tci();
    t_err();
    t_dev();
    t_drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule